// File: doc/BRIEF.md
# Wake and Interrupt Routing Controller

This block gathers wake events from a small set of external wake pins and from three internal wake sources: a real-time clock, an infrared receiver and a watchdog. Each pin has its own trigger detector, which can watch for a level, a single edge or either edge. A detected trigger is latched into a sticky status bit. Software reads, enables and clears these status bits over a plain 32-bit register bus. Every read and every write completes in a single cycle.

A single routing register holds two enable sets for every source. One set passes the source to its own routed interrupt output. The other set lets the source raise the system wake-up request. The two sets are independent of each other. Separately, the pins share one interrupt line, which is driven by the enabled status bits. The internal sources are level inputs and are never latched.

Top module: `wake_route_ctrl`

## Requirements
- R1: The register offsets are: status 0x310, pin enable 0x314, pin clear 0x318 (reads as zero), routing 0x31C, and one trigger-configuration word per pin at 0x330 + 8*i. After reset, the status, enable, clear and routing registers all read 0, and every configuration word reads 0x8 (no-trigger mode). Unmapped offsets read 0.
- R2: In the status, enable and clear registers, bit i belongs to pin i. Bits at or above NUM_PINS (at most 8) read 0, and writes to them are ignored.
- R3: Bits 3:1 of a configuration word select the trigger mode: 0 = pin low, 1 = pin high, 2 = falling edge, 3 = rising edge, 6 = either edge; any other value never triggers. An edge is detected by comparing the pin with its sample from the previous cycle, and that sample is 0 after reset.
- R4: A trigger seen in one cycle sets the pin's status bit at that clock edge. The bit stays set until it is cleared.
- R5: Writing 1 to a bit of the clear register clears that status bit at the next edge; writing 0 leaves it unchanged. If a trigger on the same pin arrives in the same cycle as the clear, the trigger wins.
- R6: `pin_irq_o` is high exactly when some pin has both its status bit and its enable bit set.
- R7: The routing register fields are: bits 8+i route pin i, bits 24+i are the wake-up enable of pin i, bits 0/1/2 route the clock/infrared/watchdog sources, and bits 16/17/18 are the wake-up enables of those sources. `pin_route_o[i]` is status[i] AND bit 8+i. `src_route_o[k]` is `src_i[k]` AND bit k.
- R8: `wake_req_o` is the OR of every pending source (a set status bit, or a high `src_i` bit) whose wake-up enable is set. It does not depend on the route enables or on the pin enable register.
- R9: Bits of the routing register outside the fields listed in R7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| wake_pin_i | input | NUM_PINS | External wake pins, synchronous to clk_i |
| src_i | input | 3 | Internal sources: bit 0 clock, bit 1 infrared, bit 2 watchdog |
| pin_irq_o | output | 1 | Shared pin interrupt |
| pin_route_o | output | NUM_PINS | Routed per-pin interrupts |
| src_route_o | output | 3 | Routed internal-source interrupts |
| wake_req_o | output | 1 | System wake-up request |

## Verification
Inputs change on the falling edge. The combinational outputs (`pin_irq_o`, the routed lines, `wake_req_o` and the read data) are compared 1 ns later, against a bench model that holds the register state as of the last rising edge. A trigger or clear driven in a given cycle therefore shows up only in the comparison of the following cycle. In that cycle the model has taken the same edge. A fixed-seed random phase mixes pin toggles, source levels and register writes. Directed sequences cover each trigger mode, the clear that coincides with a trigger, and the independence of the route enables from the wake-up enables.

// File: rtl/wkr_pkg.sv
package wkr_pkg;
   localparam int unsigned MAX_PINS        = 8;
   localparam int unsigned NUM_SRC         = 3;
   localparam int unsigned OFF_STATUS      = 'h310;
   localparam int unsigned OFF_ENABLE      = 'h314;
   localparam int unsigned OFF_CLEAR       = 'h318;
   localparam int unsigned OFF_ROUTE       = 'h31C;
   localparam int unsigned OFF_CFG_BASE    = 'h330;
   localparam int unsigned CFG_STRIDE      = 8;
   localparam int unsigned MODE_LSB        = 1;
   localparam int unsigned MODE_W          = 3;
   localparam int unsigned RT_SRC_EXT_LSB  = 0;
   localparam int unsigned RT_PIN_EXT_LSB  = 8;
   localparam int unsigned RT_SRC_WAKE_LSB = 16;
   localparam int unsigned RT_PIN_WAKE_LSB = 24;

   typedef enum logic [MODE_W-1:0] {
      MODE_LOW  = 3'd0,
      MODE_HIGH = 3'd1,
      MODE_FALL = 3'd2,
      MODE_RISE = 3'd3,
      MODE_NONE = 3'd4,
      MODE_ANY  = 3'd6
   } trig_mode_e;
endpackage

// File: rtl/wkr_pin_detect.sv
module wkr_pin_detect
   import wkr_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pin_i,
   input  logic              cfg_we_i,
   input  logic [MODE_W-1:0] cfg_mode_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              trig_o
);
   logic [MODE_W-1:0] mode_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_NONE;
         prev_q <= 1'b0;
      end else begin
         prev_q <= pin_i;
         if (cfg_we_i) mode_q <= cfg_mode_i;
      end
   end

   always_comb begin
      case (mode_q)
         MODE_LOW:  trig_o = ~pin_i;
         MODE_HIGH: trig_o = pin_i;
         MODE_FALL: trig_o = prev_q & ~pin_i;
         MODE_RISE: trig_o = ~prev_q & pin_i;
         MODE_ANY:  trig_o = prev_q ^ pin_i;
         default:   trig_o = 1'b0;
      endcase
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/wkr_status_bank.sv
module wkr_status_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] trig_i,
   input  logic [N-1:0] clr_i,
   input  logic         en_we_i,
   input  logic [N-1:0] en_wdata_i,
   output logic [N-1:0] status_o,
   output logic [N-1:0] enable_o
);
   logic [N-1:0] status_q, enable_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_i) | trig_i;
         if (en_we_i) enable_q <= en_wdata_i;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
endmodule

// File: rtl/wkr_route_unit.sv
module wkr_route_unit
   import wkr_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [N-1:0]       pin_ext_wd_i,
   input  logic [N-1:0]       pin_wake_wd_i,
   input  logic [NUM_SRC-1:0] src_ext_wd_i,
   input  logic [NUM_SRC-1:0] src_wake_wd_i,
   input  logic [N-1:0]       status_i,
   input  logic [N-1:0]       enable_i,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [N-1:0]       pin_ext_o,
   output logic [N-1:0]       pin_wake_o,
   output logic [NUM_SRC-1:0] src_ext_o,
   output logic [NUM_SRC-1:0] src_wake_o,
   output logic               pin_irq_o,
   output logic [N-1:0]       pin_route_o,
   output logic [NUM_SRC-1:0] src_route_o,
   output logic               wake_req_o
);
   logic [N-1:0]       pin_ext_q, pin_wake_q;
   logic [NUM_SRC-1:0] src_ext_q, src_wake_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_ext_q  <= '0;
         pin_wake_q <= '0;
         src_ext_q  <= '0;
         src_wake_q <= '0;
      end else if (we_i) begin
         pin_ext_q  <= pin_ext_wd_i;
         pin_wake_q <= pin_wake_wd_i;
         src_ext_q  <= src_ext_wd_i;
         src_wake_q <= src_wake_wd_i;
      end
   end

   assign pin_irq_o   = |(status_i & enable_i);
   assign pin_route_o = status_i & pin_ext_q;
   assign src_route_o = src_i & src_ext_q;
   assign wake_req_o  = (|(status_i & pin_wake_q)) | (|(src_i & src_wake_q));

   assign pin_ext_o  = pin_ext_q;
   assign pin_wake_o = pin_wake_q;
   assign src_ext_o  = src_ext_q;
   assign src_wake_o = src_wake_q;
endmodule

// File: rtl/wake_route_ctrl.sv
module wake_route_ctrl
   import wkr_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_we_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   input  logic [NUM_PINS-1:0] wake_pin_i,
   input  logic [NUM_SRC-1:0]  src_i,
   output logic                pin_irq_o,
   output logic [NUM_PINS-1:0] pin_route_o,
   output logic [NUM_SRC-1:0]  src_route_o,
   output logic                wake_req_o
);
   localparam int unsigned LAST_CFG = OFF_CFG_BASE + (MAX_PINS - 1) * CFG_STRIDE;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("NUM_PINS out of range");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if ((LAST_CFG >> ADDR_W) != 0) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic hit_enable, hit_clear, hit_route;
   logic [NUM_PINS-1:0] trig_w, status_w, en_w, clr_w, cfg_we;
   logic [NUM_PINS-1:0] pin_ext_w, pin_wake_w;
   logic [NUM_SRC-1:0]  src_ext_w, src_wake_w;
   logic [MODE_W-1:0]   pin_mode [NUM_PINS];
   logic                wdata_unused;

   assign hit_enable   = bus_addr_i == ADDR_W'(OFF_ENABLE);
   assign hit_clear    = bus_addr_i == ADDR_W'(OFF_CLEAR);
   assign hit_route    = bus_addr_i == ADDR_W'(OFF_ROUTE);
   assign clr_w        = (bus_we_i && hit_clear) ? bus_wdata_i[NUM_PINS-1:0] : '0;
   assign wdata_unused = ^bus_wdata_i;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign cfg_we[g] = bus_we_i &&
                         (bus_addr_i == ADDR_W'(OFF_CFG_BASE + g * CFG_STRIDE));
      wkr_pin_detect u_det (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .pin_i      (wake_pin_i[g]),
         .cfg_we_i   (cfg_we[g]),
         .cfg_mode_i (bus_wdata_i[MODE_LSB +: MODE_W]),
         .mode_o     (pin_mode[g]),
         .trig_o     (trig_w[g])
      );
   end

   wkr_status_bank #(.N(NUM_PINS)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (trig_w),
      .clr_i      (clr_w),
      .en_we_i    (bus_we_i && hit_enable),
      .en_wdata_i (bus_wdata_i[NUM_PINS-1:0]),
      .status_o   (status_w),
      .enable_o   (en_w)
   );

   wkr_route_unit #(.N(NUM_PINS)) u_route (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .we_i          (bus_we_i && hit_route),
      .pin_ext_wd_i  (bus_wdata_i[RT_PIN_EXT_LSB +: NUM_PINS]),
      .pin_wake_wd_i (bus_wdata_i[RT_PIN_WAKE_LSB +: NUM_PINS]),
      .src_ext_wd_i  (bus_wdata_i[RT_SRC_EXT_LSB +: NUM_SRC]),
      .src_wake_wd_i (bus_wdata_i[RT_SRC_WAKE_LSB +: NUM_SRC]),
      .status_i      (status_w),
      .enable_i      (en_w),
      .src_i         (src_i),
      .pin_ext_o     (pin_ext_w),
      .pin_wake_o    (pin_wake_w),
      .src_ext_o     (src_ext_w),
      .src_wake_o    (src_wake_w),
      .pin_irq_o     (pin_irq_o),
      .pin_route_o   (pin_route_o),
      .src_route_o   (src_route_o),
      .wake_req_o    (wake_req_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(OFF_STATUS)) begin
         bus_rdata_o[NUM_PINS-1:0] = status_w;
      end else if (hit_enable) begin
         bus_rdata_o[NUM_PINS-1:0] = en_w;
      end else if (hit_route) begin
         bus_rdata_o[RT_PIN_EXT_LSB +: NUM_PINS]  = pin_ext_w;
         bus_rdata_o[RT_PIN_WAKE_LSB +: NUM_PINS] = pin_wake_w;
         bus_rdata_o[RT_SRC_EXT_LSB +: NUM_SRC]   = src_ext_w;
         bus_rdata_o[RT_SRC_WAKE_LSB +: NUM_SRC]  = src_wake_w;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr_i == ADDR_W'(OFF_CFG_BASE + i * CFG_STRIDE))
               bus_rdata_o[MODE_LSB +: MODE_W] = pin_mode[i];
         end
      end
   end
endmodule

// File: rtl/wkr_chk.sv
module wkr_chk
   import wkr_pkg::*;
#(
   parameter int unsigned N      = 4,
   parameter int unsigned ADDR_W = 12
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               we_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic [N-1:0]       wdata_i,
   input logic [N-1:0]       trig_i,
   input logic [N-1:0]       status_i,
   input logic [N-1:0]       enable_i,
   input logic               pin_irq_i,
   input logic               wake_req_i,
   input logic [N-1:0]       pin_wake_i,
   input logic [NUM_SRC-1:0] src_wake_i
);
   logic clr_wr;
   assign clr_wr = we_i && (addr_i == ADDR_W'(OFF_CLEAR));

   // R5
   clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr |=> ((status_i & $past(wdata_i & ~trig_i)) == '0));

   // R5
   trig_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i != '0) |=> ((status_i & $past(trig_i)) == $past(trig_i)));

   // R4
   sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_wr |=> ((status_i & $past(status_i)) == $past(status_i)));

   // R6
   irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_irq_i |-> ((enable_i != '0) && (status_i != '0)));

   // R8
   wake_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_req_i |-> ((pin_wake_i != '0) || (src_wake_i != '0)));
endmodule

bind wake_route_ctrl wkr_chk #(.N(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .we_i       (bus_we_i),
   .addr_i     (bus_addr_i),
   .wdata_i    (bus_wdata_i[NUM_PINS-1:0]),
   .trig_i     (trig_w),
   .status_i   (status_w),
   .enable_i   (en_w),
   .pin_irq_i  (pin_irq_o),
   .wake_req_i (wake_req_o),
   .pin_wake_i (pin_wake_w),
   .src_wake_i (src_wake_w)
);

// File: tb/wake_route_ctrl_tb.sv
`timescale 1ns/1ps
module wake_route_ctrl_tb_top;
   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NP-1:0] pins = '0;
   logic [2:0]  src = '0;
   logic        pin_irq, wake_req;
   logic [NP-1:0] pin_route;
   logic [2:0]  src_route;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   wake_route_ctrl #(.NUM_PINS(NP)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wake_pin_i(pins), .src_i(src),
      .pin_irq_o(pin_irq), .pin_route_o(pin_route), .src_route_o(src_route),
      .wake_req_o(wake_req)
   );

   // bench model of the register state
   logic [NP-1:0] m_stat, m_en, m_pext, m_pwake, m_prev;
   logic [2:0]    m_sext, m_swake;
   logic [2:0]    m_mode [NP];

   function automatic logic mtrig(logic [2:0] mode, logic prev, logic cur);
      case (mode)
         3'd0: return !cur;
         3'd1: return cur;
         3'd2: return prev && !cur;
         3'd3: return !prev && cur;
         3'd6: return prev != cur;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      logic [31:0] r = '0;
      if (a == 12'h310) r[NP-1:0] = m_stat;
      else if (a == 12'h314) r[NP-1:0] = m_en;
      else if (a == 12'h31C) begin
         r[8 +: NP] = m_pext; r[24 +: NP] = m_pwake;
         r[2:0] = m_sext; r[18:16] = m_swake;
      end else
         for (int i = 0; i < NP; i++)
            if (a == 12'(12'h330 + 8 * i)) r[3:1] = m_mode[i];
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(logic [NP-1:0] p, logic [2:0] s, logic w,
                       logic [11:0] a, logic [31:0] d, string tag);
      logic [NP-1:0] trig, clr;
      pins = p; src = s; we = w; addr = a; wdata = d;
      #1;
      chk("R6 pin_irq", 32'(pin_irq), 32'(|(m_stat & m_en)));
      chk("R7 pin_route", 32'(pin_route), 32'(m_stat & m_pext));
      chk("R7 src_route", 32'(src_route), 32'(s & m_sext));
      chk("R8 wake_req", 32'(wake_req),
          32'((|(m_stat & m_pwake)) | (|(s & m_swake))));
      chk(tag, rdata, exp_rd(a));
      for (int i = 0; i < NP; i++) trig[i] = mtrig(m_mode[i], m_prev[i], p[i]);
      clr = (w && a == 12'h318) ? d[NP-1:0] : '0;
      m_stat = (m_stat & ~clr) | trig;
      m_prev = p;
      if (w) begin
         if (a == 12'h314) m_en = d[NP-1:0];
         if (a == 12'h31C) begin
            m_pext = d[8 +: NP]; m_pwake = d[24 +: NP];
            m_sext = d[2:0]; m_swake = d[18:16];
         end
         for (int i = 0; i < NP; i++)
            if (a == 12'(12'h330 + 8 * i)) m_mode[i] = d[3:1];
      end
      @(negedge clk);
   endtask

   task automatic rd(logic [11:0] a, string tag);
      step(pins, src, 1'b0, a, 32'h0, tag);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
      step(pins, src, 1'b1, a, d, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [11:0] amap [10];
      void'($urandom(32'd20240607));
      m_stat = '0; m_en = '0; m_pext = '0; m_pwake = '0; m_prev = '0;
      m_sext = '0; m_swake = '0;
      for (int i = 0; i < NP; i++) m_mode[i] = 3'd4;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values and map
      rd(12'h310, "R1 status reset"); rd(12'h314, "R1 enable reset");
      rd(12'h318, "R1 clear reads zero"); rd(12'h31C, "R1 route reset");
      for (int i = 0; i < NP; i++) rd(12'(12'h330 + 8 * i), "R1 cfg reset");
      rd(12'h320, "R1 unmapped");

      // R2 upper bits ignored
      wr(12'h314, 32'hFFFF_FFFF, "R2 write enable"); rd(12'h314, "R2 enable width");
      // R9 unused route bits
      wr(12'h31C, 32'hFFFF_FFFF, "R9 write route"); rd(12'h31C, "R9 route readback");
      wr(12'h31C, 32'h0, "R9 clear route");

      // R3 each mode on pin 0
      wr(12'h330, 32'h6, "R3 rising cfg");
      step(4'h1, 3'h0, 1'b0, 12'h310, 0, "R3 rise seen");
      rd(12'h310, "R3 rise latched");
      wr(12'h318, 32'h1, "R5 clear pin0");
      rd(12'h310, "R5 cleared");
      step(4'h0, 3'h0, 1'b0, 12'h310, 0, "R3 fall ignored by rise");
      wr(12'h330, 32'h4, "R3 falling cfg");
      step(4'h1, 3'h0, 1'b0, 12'h310, 0, "R3 setup");
      step(4'h0, 3'h0, 1'b0, 12'h310, 0, "R3 falling");
      rd(12'h310, "R3 fall latched");
      wr(12'h330, 32'hC, "R3 either cfg");
      wr(12'h318, 32'h1, "R5 clear");
      step(4'h1, 3'h0, 1'b0, 12'h310, 0, "R3 either edge");
      rd(12'h310, "R3 either latched");
      wr(12'h330, 32'hA, "R3 unused mode 5");
      wr(12'h318, 32'hF, "R5 clear all");
      step(4'h0, 3'h0, 1'b0, 12'h310, 0, "R3 mode5 no trig");
      rd(12'h310, "R3 mode5 status");

      // R5 clear vs simultaneous trigger (pin1 high level)
      wr(12'h338, 32'h2, "R3 high level cfg");
      step(4'h2, 3'h0, 1'b0, 12'h310, 0, "R4 level trig");
      step(4'h2, 3'h0, 1'b1, 12'h318, 32'h2, "R5 clear during trigger");
      rd(12'h310, "R5 trigger wins");
      step(4'h0, 3'h0, 1'b1, 12'h318, 32'h0, "R5 zero write");
      rd(12'h310, "R5 zero write keeps status");

      // R7/R8 independence
      wr(12'h314, 32'h0, "R6 disable");
      wr(12'h31C, 32'h0200_0000, "R8 wake only pin1");
      step(4'h0, 3'h5, 1'b0, 12'h31C, 0, "R8 wake from pin1");
      wr(12'h31C, 32'h0001_0202, "R7 route pin1 and ir, wake rtc");
      step(4'h0, 3'h3, 1'b0, 12'h310, 0, "R7 routes");
      wr(12'h314, 32'h2, "R6 enable pin1");
      rd(12'h310, "R6 irq up");

      // random phase
      amap = '{12'h310, 12'h314, 12'h318, 12'h31C, 12'h330, 12'h338,
               12'h340, 12'h348, 12'h320, 12'h318};
      for (int n = 0; n < 4000; n++) begin
         logic [11:0] a;
         logic [31:0] d;
         logic w;
         a = amap[$urandom_range(9)];
         w = ($urandom_range(3) == 0);
         d = $urandom;
         step(NP'($urandom), 3'($urandom), w, a, d, "R4 random readback");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule